// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache

This block is a 64-byte cache that sits between a byte-wide processor port and a memory that moves 8-byte lines. The address space is 256 bytes. The cache is built from four sets, and each set holds two ways. A request is taken while the cache is idle, and the tag lookup happens in the next cycle. A hit gives its response at once. A miss stalls the processor port while the controller writes back a dirty victim, if there is one, and then fetches the missing line.

Two compile-time switches set the write behaviour. The first chooses between write-back with dirty tracking and write-through. The second decides whether a write miss brings the line into the cache or sends the byte straight to memory. Two saturating counters track the lookups and the hits, so the hit rate can be read out.

Top module: `two_way_cache`

## Requirements
- R1: After reset, `cpuBusy`, `cpuValid` and `memReq` are low and both counters read zero. Every line is invalid, so the first access to any line misses.
- R2: The address splits into tag = bits 7:5, set = bits 4:3 and byte offset = bits 2:0. A lookup hits only when a valid way in the selected set holds the same tag. A read returns the byte at the offset. `cpuValid` is high for exactly one cycle per accepted request.
- R3: On a miss, an invalid way is always filled before any valid way is replaced. Two lines with the same set index can be resident at once, so reading 0x00, 0x40, 0x00, 0x40, 0x00, 0x40 gives miss, miss, hit, hit, hit, hit.
- R4: When both ways are valid, the victim is the least recently used way. Every hit and every fill makes the touched way the most recent one.
- R5: With write-back selected, a write hit causes no memory traffic and marks the line dirty. Evicting a dirty line writes the whole 8-byte line back to memory before the fetch of the new line is issued. Evicting a clean line writes nothing.
- R6: With write-through selected, every write produces a single-byte memory write, and no line is ever written back on eviction.
- R7: With allocate selected, a write miss fetches the line, merges the written byte into it and leaves the line resident, so a later read of that line hits.
- R8: With no-allocate selected, a write miss sends the byte to memory, performs no fetch and leaves the cache contents unchanged.
- R9: `memReq` stays high with a stable `memAddr` until `memAck` is seen. Line transfers use `memAddr` with offset 0, and a line write sets all 8 bits of `memBe`. A byte write carries the full byte address, sets the single `memBe` bit at the offset, and copies the byte into every lane of `memWdata`.
- R10: `cpuBusy` is high from the lookup cycle until the response. Any request presented while `cpuBusy` is high is ignored.
- R11: `accessCount` counts lookups and `hitCount` counts hits. Both are `CNT_W`-bit counters (16 by default) that saturate at their maximum value, and `hitCount` never exceeds `accessCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, taken while `cpuBusy` is low |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 8 | Byte address |
| cpuWdata | input | 8 | Write byte |
| cpuBusy | output | 1 | Controller is handling a request |
| cpuValid | output | 1 | One-cycle response strobe |
| cpuHit | output | 1 | The lookup for the response hit |
| cpuRdata | output | 8 | Read byte, valid together with `cpuValid` on reads |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = memory write, 0 = line fetch |
| memAddr | output | 8 | Memory byte address |
| memWdata | output | 64 | Write data, byte lane i = bits 8i+7:8i |
| memBe | output | 8 | Byte enables for writes |
| memAck | input | 1 | One-cycle acknowledge; for a fetch, `memRdata` is valid in that cycle |
| memRdata | input | 64 | Fetched line |
| hitCount | output | CNT_W | Saturating hit counter |
| accessCount | output | CNT_W | Saturating lookup counter |

## Verification
Full ascending sweeps of all 256 addresses are run with writes and then with reads. They separate the first-byte miss of each line from the seven hits that follow it. On the write-back build they also show that dirty lines come back intact after eviction. On the write-through, no-allocate build they show that every write reaches memory and that no line is allocated. Short directed sequences on one set tell true least-recently-used order apart from fill order. They also tell a dirty eviction from a clean one. A request raised in the middle of a miss shows that input is ignored while busy. The counters are checked at exact totals on one build, and at saturation on a narrow counter on the other.

// File: rtl/two_way_cache_pkg.sv
package two_way_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WBACK,
    ST_FETCH,
    ST_WTHRU
  } ctrlStateT;

  typedef enum logic [1:0] {
    OP_FETCH,
    OP_BLOCK_WR,
    OP_BYTE_WR
  } memOpT;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic  latchReq;
    logic  countAccess;
    logic  hitUpdate;
    logic  holdVictim;
    logic  fillLine;
    memOpT memOp;
  } dpStrobeT;

endpackage

// File: rtl/two_way_cache_dp.sv
module two_way_cache_dp
  import two_way_cache_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 2,
  parameter int OFF_W      = 3,
  parameter int CNT_W      = 16,
  parameter int WRITE_BACK = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobeT                  strobe,
  input  logic                      cpuWe,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [7:0]                cpuWdata,
  input  logic [(8<<OFF_W)-1:0]     memRdata,
  output logic                      lookupHit,
  output logic                      victimDirty,
  output logic                      reqWe,
  output logic [7:0]                cpuRdata,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [(8<<OFF_W)-1:0]     memWdata,
  output logic [(1<<OFF_W)-1:0]     memBe,
  output logic [CNT_W-1:0]          hitCount,
  output logic [CNT_W-1:0]          accessCount
);

  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int LINE_B = 1 << OFF_W;
  localparam int LINE_W = 8 * LINE_B;
  localparam int WAYS   = 2;

  logic [ADDR_W-1:0] reqAddr;
  logic [7:0]        reqWdata;
  logic [TAG_W-1:0]  tagArr   [WAYS][SETS];
  logic [LINE_W-1:0] dataArr  [WAYS][SETS];
  logic [SETS-1:0]   validArr [WAYS];
  logic [SETS-1:0]   dirtyArr [WAYS];
  logic [SETS-1:0]   lruWay;
  logic [WAYS-1:0]   wayMatch;
  logic              hitWay, vicWay, vicWayQ;
  logic [LINE_W-1:0] fillMerged, vicLine, hitLine;

  wire [TAG_W-1:0] reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] reqIdx = reqAddr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] reqOff = reqAddr[OFF_W-1:0];
  wire [OFF_W+2:0] bitPos = {reqOff, 3'b000};

  // parallel tag compare, one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayMatch[w] = validArr[w][reqIdx] && (tagArr[w][reqIdx] == reqTag);
  end

  assign lookupHit = |wayMatch;
  assign hitWay    = wayMatch[1];

  // invalid ways are chosen before the LRU way
  always_comb begin
    if (!validArr[0][reqIdx])      vicWay = 1'b0;
    else if (!validArr[1][reqIdx]) vicWay = 1'b1;
    else                           vicWay = lruWay[reqIdx];
  end
  assign victimDirty = validArr[vicWay][reqIdx] && dirtyArr[vicWay][reqIdx];

  always_comb begin
    hitLine    = dataArr[hitWay][reqIdx];
    vicLine    = dataArr[vicWayQ][reqIdx];
    fillMerged = memRdata;
    if (reqWe) fillMerged[bitPos +: 8] = reqWdata;
  end

  always_comb begin
    case (strobe.memOp)
      OP_BLOCK_WR: begin
        memAddr  = {tagArr[vicWayQ][reqIdx], reqIdx, {OFF_W{1'b0}}};
        memWdata = vicLine;
        memBe    = '1;
      end
      OP_BYTE_WR: begin
        memAddr  = reqAddr;
        memWdata = {LINE_B{reqWdata}};
        memBe    = {{(LINE_B-1){1'b0}}, 1'b1} << reqOff;
      end
      default: begin
        memAddr  = {reqTag, reqIdx, {OFF_W{1'b0}}};
        memWdata = {LINE_B{reqWdata}};
        memBe    = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr     <= '0;
      reqWe       <= 1'b0;
      reqWdata    <= '0;
      vicWayQ     <= 1'b0;
      cpuRdata    <= '0;
      lruWay      <= '0;
      hitCount    <= '0;
      accessCount <= '0;
      for (int w = 0; w < WAYS; w++) begin
        validArr[w] <= '0;
        dirtyArr[w] <= '0;
        for (int s = 0; s < SETS; s++) tagArr[w][s] <= '0;
      end
    end else begin
      if (strobe.latchReq) begin
        reqAddr  <= cpuAddr;
        reqWe    <= cpuWe;
        reqWdata <= cpuWdata;
      end
      if (strobe.countAccess) begin
        if (accessCount != '1) accessCount <= accessCount + 1'b1;
        if (lookupHit && hitCount != '1) hitCount <= hitCount + 1'b1;
      end
      if (strobe.holdVictim) vicWayQ <= vicWay;
      if (strobe.hitUpdate) begin
        lruWay[reqIdx] <= ~hitWay;
        cpuRdata       <= hitLine[bitPos +: 8];
        if (reqWe && WRITE_BACK != 0) dirtyArr[hitWay][reqIdx] <= 1'b1;
      end
      if (strobe.fillLine) begin
        tagArr[vicWayQ][reqIdx]   <= reqTag;
        validArr[vicWayQ][reqIdx] <= 1'b1;
        dirtyArr[vicWayQ][reqIdx] <= (WRITE_BACK != 0) && reqWe;
        lruWay[reqIdx]            <= ~vicWayQ;
        cpuRdata                  <= fillMerged[bitPos +: 8];
      end
    end
  end

  // line storage carries no reset
  always_ff @(posedge clk) begin
    if (strobe.hitUpdate && reqWe) dataArr[hitWay][reqIdx][bitPos +: 8] <= reqWdata;
    if (strobe.fillLine)           dataArr[vicWayQ][reqIdx] <= fillMerged;
  end

  AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countAccess |-> $onehot0(wayMatch)); // R3
  AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    hitCount <= accessCount); // R11
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillLine |=> lookupHit); // R7

endmodule

// File: rtl/two_way_cache_ctrl.sv
module two_way_cache_ctrl
  import two_way_cache_pkg::*;
#(
  parameter int WRITE_BACK  = 1,
  parameter int WRITE_ALLOC = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuReq,
  input  logic     lookupHit,
  input  logic     victimDirty,
  input  logic     reqWe,
  input  logic     memAck,
  output dpStrobeT strobe,
  output logic     memReq,
  output logic     memWe,
  output logic     cpuBusy,
  output logic     cpuValid,
  output logic     cpuHit
);

  ctrlStateT state, nextState;
  logic      respond, hitSeenQ;

  always_comb begin
    strobe       = '0;
    strobe.memOp = OP_FETCH;
    nextState    = state;
    respond      = 1'b0;
    memReq       = 1'b0;
    memWe        = 1'b0;
    case (state)
      ST_IDLE: if (cpuReq) begin
        strobe.latchReq = 1'b1;
        nextState       = ST_CMP;
      end
      ST_CMP: begin
        strobe.countAccess = 1'b1;
        if (lookupHit) begin
          strobe.hitUpdate = 1'b1;
          if (reqWe && WRITE_BACK == 0) nextState = ST_WTHRU;
          else begin
            respond   = 1'b1;
            nextState = ST_IDLE;
          end
        end else if (reqWe && WRITE_ALLOC == 0) begin
          nextState = ST_WTHRU;
        end else begin
          strobe.holdVictim = 1'b1;
          nextState = victimDirty ? ST_WBACK : ST_FETCH;
        end
      end
      ST_WBACK: begin
        strobe.memOp = OP_BLOCK_WR;
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nextState = ST_FETCH;
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fillLine = 1'b1;
          if (reqWe && WRITE_BACK == 0) nextState = ST_WTHRU;
          else begin
            respond   = 1'b1;
            nextState = ST_IDLE;
          end
        end
      end
      ST_WTHRU: begin
        strobe.memOp = OP_BYTE_WR;
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          respond   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign cpuBusy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cpuValid <= 1'b0;
      cpuHit   <= 1'b0;
      hitSeenQ <= 1'b0;
    end else begin
      state    <= nextState;
      cpuValid <= respond;
      if (state == ST_CMP) hitSeenQ <= lookupHit;
      if (respond) cpuHit <= (state == ST_CMP) ? lookupHit : hitSeenQ;
    end
  end

  AST_MEM_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> cpuBusy); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |=> !cpuValid); // R2

endmodule

// File: rtl/two_way_cache.sv
module two_way_cache
  import two_way_cache_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 2,
  parameter int OFF_W       = 3,
  parameter int CNT_W       = 16,
  parameter int WRITE_BACK  = 1,
  parameter int WRITE_ALLOC = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuReq,
  input  logic                  cpuWe,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [7:0]            cpuWdata,
  output logic                  cpuBusy,
  output logic                  cpuValid,
  output logic                  cpuHit,
  output logic [7:0]            cpuRdata,
  output logic                  memReq,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [(8<<OFF_W)-1:0] memWdata,
  output logic [(1<<OFF_W)-1:0] memBe,
  input  logic                  memAck,
  input  logic [(8<<OFF_W)-1:0] memRdata,
  output logic [CNT_W-1:0]      hitCount,
  output logic [CNT_W-1:0]      accessCount
);

  dpStrobeT strobe;
  logic     lookupHit, victimDirty, reqWe;

  two_way_cache_ctrl #(
    .WRITE_BACK (WRITE_BACK),
    .WRITE_ALLOC(WRITE_ALLOC)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .lookupHit  (lookupHit),
    .victimDirty(victimDirty),
    .reqWe      (reqWe),
    .memAck     (memAck),
    .strobe     (strobe),
    .memReq     (memReq),
    .memWe      (memWe),
    .cpuBusy    (cpuBusy),
    .cpuValid   (cpuValid),
    .cpuHit     (cpuHit)
  );

  two_way_cache_dp #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .OFF_W     (OFF_W),
    .CNT_W     (CNT_W),
    .WRITE_BACK(WRITE_BACK)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuWe      (cpuWe),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .memRdata   (memRdata),
    .lookupHit  (lookupHit),
    .victimDirty(victimDirty),
    .reqWe      (reqWe),
    .cpuRdata   (cpuRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memBe      (memBe),
    .hitCount   (hitCount),
    .accessCount(accessCount)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWe)); // R9
  AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && (&memBe) && memAck |=> memReq && !memWe); // R5
  AST_WT_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (WRITE_BACK == 0) && memReq && memWe |-> $countones(memBe) == 1); // R6

endmodule

// File: tb/two_way_cache_tb_top.sv
module two_way_cache_mem_model (
  input  logic        clk,
  input  logic        rstN,
  input  logic        memReq,
  input  logic        memWe,
  input  logic [7:0]  memAddr,
  input  logic [63:0] memWdata,
  input  logic [7:0]  memBe,
  output logic        memAck,
  output logic [63:0] memRdata,
  input  logic [7:0]  peekAddr,
  output logic [7:0]  peekData,
  output int          nFetch,
  output int          nBlockWr,
  output int          nByteWr,
  output logic [7:0]  lastAddr,
  output logic [7:0]  lastBe
);
  logic [7:0] mem [256];
  int         waitCnt;

  assign peekData = mem[peekAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < 256; a++) mem[a] <= 8'(a) ^ 8'h5A;
      memAck   <= 1'b0;
      memRdata <= '0;
      waitCnt  <= 0;
      nFetch   <= 0;
      nBlockWr <= 0;
      nByteWr  <= 0;
      lastAddr <= '0;
      lastBe   <= '0;
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        if (waitCnt == 2) begin
          waitCnt <= 0;
          memAck  <= 1'b1;
          if (memWe) begin
            for (int b = 0; b < 8; b++)
              if (memBe[b]) mem[{memAddr[7:3], 3'(b)}] <= memWdata[8*b +: 8];
            if (&memBe) nBlockWr <= nBlockWr + 1;
            else        nByteWr  <= nByteWr + 1;
            lastAddr <= memAddr;
            lastBe   <= memBe;
          end else begin
            for (int b = 0; b < 8; b++) memRdata[8*b +: 8] <= mem[{memAddr[7:3], 3'(b)}];
            nFetch <= nFetch + 1;
          end
        end else begin
          waitCnt <= waitCnt + 1;
        end
      end
    end
  end
endmodule

module two_way_cache_tb_top;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       req [2];
  logic       we  [2];
  logic [7:0] addr[2];
  logic [7:0] wdat[2];
  logic       busy[2], valid[2], hit[2];
  logic [7:0] rdat[2];
  logic       mReq[2], mWe[2], mAck[2];
  logic [7:0] mAddr[2], mBe[2];
  logic [63:0] mWdata[2], mRdata[2];
  logic [3:0]  hc0, ac0;
  logic [15:0] hc1, ac1;
  int          nFetch[2], nBlk[2], nByte[2];
  logic [7:0]  lastAddr[2], lastBe[2];
  logic [7:0]  peekAddr;
  logic [7:0]  peekData[2];
  logic [7:0]  shadow[2][256];

  int nCmp = 0;
  int nBad = 0;

  // write-back, allocate, narrow counters
  two_way_cache #(.CNT_W(4), .WRITE_BACK(1), .WRITE_ALLOC(1)) dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(req[0]), .cpuWe(we[0]), .cpuAddr(addr[0]),
    .cpuWdata(wdat[0]), .cpuBusy(busy[0]), .cpuValid(valid[0]), .cpuHit(hit[0]),
    .cpuRdata(rdat[0]), .memReq(mReq[0]), .memWe(mWe[0]), .memAddr(mAddr[0]),
    .memWdata(mWdata[0]), .memBe(mBe[0]), .memAck(mAck[0]), .memRdata(mRdata[0]),
    .hitCount(hc0), .accessCount(ac0));

  // write-through, no-allocate, default counters
  two_way_cache #(.WRITE_BACK(0), .WRITE_ALLOC(0)) dutWt_i (
    .clk(clk), .rstN(rstN), .cpuReq(req[1]), .cpuWe(we[1]), .cpuAddr(addr[1]),
    .cpuWdata(wdat[1]), .cpuBusy(busy[1]), .cpuValid(valid[1]), .cpuHit(hit[1]),
    .cpuRdata(rdat[1]), .memReq(mReq[1]), .memWe(mWe[1]), .memAddr(mAddr[1]),
    .memWdata(mWdata[1]), .memBe(mBe[1]), .memAck(mAck[1]), .memRdata(mRdata[1]),
    .hitCount(hc1), .accessCount(ac1));

  for (genvar d = 0; d < 2; d++) begin : g_mem
    two_way_cache_mem_model mem_i (
      .clk(clk), .rstN(rstN), .memReq(mReq[d]), .memWe(mWe[d]), .memAddr(mAddr[d]),
      .memWdata(mWdata[d]), .memBe(mBe[d]), .memAck(mAck[d]), .memRdata(mRdata[d]),
      .peekAddr(peekAddr), .peekData(peekData[d]), .nFetch(nFetch[d]),
      .nBlockWr(nBlk[d]), .nByteWr(nByte[d]), .lastAddr(lastAddr[d]), .lastBe(lastBe[d]));
  end

  task automatic chk(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    for (int d = 0; d < 2; d++) begin
      req[d] = 1'b0; we[d] = 1'b0; addr[d] = '0; wdat[d] = '0;
      for (int a = 0; a < 256; a++) shadow[d][a] = 8'(a) ^ 8'h5A;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic access(int d, bit w, logic [7:0] a, logic [7:0] v,
                        output logic [7:0] rd, output bit h);
    int g;
    @(negedge clk);
    while (busy[d]) @(negedge clk);
    req[d] = 1'b1; we[d] = w; addr[d] = a; wdat[d] = v;
    @(negedge clk);
    req[d] = 1'b0;
    g = 0;
    while (!valid[d] && g < 200) begin
      @(negedge clk);
      g++;
    end
    if (g >= 200) chk("R10 response missing", 0, 1);
    rd = rdat[d];
    h  = hit[d];
  endtask

  task automatic expectRead(int d, logic [7:0] a, bit expHit, string tag);
    logic [7:0] rd;
    bit h;
    access(d, 1'b0, a, 8'h00, rd, h);
    chk({tag, " hit"}, int'(h), int'(expHit));
    chk({tag, " data"}, int'(rd), int'(shadow[d][a]));
  endtask

  task automatic writeExp(int d, logic [7:0] a, logic [7:0] v, bit expHit, string tag);
    logic [7:0] rd;
    bit h;
    access(d, 1'b1, a, v, rd, h);
    chk({tag, " hit"}, int'(h), int'(expHit));
    shadow[d][a] = v;
  endtask

  task automatic sweepWrite(int d, bit allocExp, string tag);
    for (int a = 0; a < 256; a++)
      writeExp(d, 8'(a), 8'(a * 7 + 3), allocExp && (a % 8 != 0), tag);
  endtask

  task automatic sweepRead(int d, string tag);
    for (int a = 0; a < 256; a++) expectRead(d, 8'(a), (a % 8) != 0, tag);
  endtask

  task automatic peekChk(int d, logic [7:0] a, logic [7:0] exp, string tag);
    peekAddr = a;
    #1;
    chk(tag, int'(peekData[d]), int'(exp));
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int f0;
    peekAddr = '0;
    doReset();

    // R1 reset state
    chk("R1 busy", int'(busy[0]), 0);
    chk("R1 valid", int'(valid[0]), 0);
    chk("R1 memReq", int'(mReq[0]), 0);
    chk("R1 accessCount", int'(ac0), 0);
    chk("R1 hitCount", int'(hc0), 0);
    chk("R1 wt busy", int'(busy[1]), 0);

    // R3 alternating lines sharing set 0; R1 first access misses; R2 data
    for (int i = 0; i < 6; i++)
      expectRead(0, (i % 2 == 0) ? 8'h00 : 8'h40, i >= 2, "R3 R2 alternate");
    chk("R3 fetches", nFetch[0], 2);
    chk("R11 accesses", int'(ac0), 6);
    chk("R11 hits", int'(hc0), 4);

    // R4 LRU order in set 0
    expectRead(0, 8'h80, 1'b0, "R4 evict A");
    expectRead(0, 8'h40, 1'b1, "R4 B kept");
    expectRead(0, 8'h00, 1'b0, "R4 A refetch");
    expectRead(0, 8'h80, 1'b0, "R4 C evicted");

    // R5 write-back: write hit silent, dirty eviction writes the line
    writeExp(0, 8'h01, 8'h77, 1'b1, "R5 write hit");
    chk("R5 no byte write", nByte[0], 0);
    chk("R5 no line write", nBlk[0], 0);
    expectRead(0, 8'h40, 1'b0, "R5 clean evict");
    chk("R5 clean no writeback", nBlk[0], 0);
    expectRead(0, 8'h80, 1'b0, "R5 dirty evict");
    chk("R5 writeback count", nBlk[0], 1);
    chk("R9 writeback addr", int'(lastAddr[0]), 8'h00);
    chk("R9 writeback be", int'(lastBe[0]), 8'hFF);
    peekChk(0, 8'h01, 8'h77, "R5 memory updated");
    expectRead(0, 8'h01, 1'b0, "R5 reload");

    // R7 allocate on write miss
    f0 = nFetch[0];
    writeExp(0, 8'hA3, 8'h3C, 1'b0, "R7 write miss");
    chk("R7 fetch on write miss", nFetch[0], f0 + 1);
    expectRead(0, 8'hA3, 1'b1, "R7 merged byte");
    expectRead(0, 8'hA4, 1'b1, "R7 rest of line");

    // R11 narrow counters saturate
    chk("R11 access saturate", int'(ac0), 15);
    chk("R11 hits", int'(hc0), 8);

    // R5 R7 full sweeps on write-back build
    doReset();
    sweepWrite(0, 1'b1, "R7 sweep write");
    chk("R5 sweep writebacks", nBlk[0], 24);
    sweepRead(0, "R5 sweep read");
    chk("R5 total writebacks", nBlk[0], 32);
    chk("R11 hit saturate", int'(hc0), 15);
    chk("R11 access saturate", int'(ac0), 15);

    // R10 request while busy is ignored
    doReset();
    begin
      logic [7:0] rd;
      int g;
      @(negedge clk);
      req[1] = 1'b1; we[1] = 1'b0; addr[1] = 8'h20; wdat[1] = 8'h00;
      @(negedge clk);
      we[1] = 1'b1; addr[1] = 8'h10; wdat[1] = 8'hEE;
      repeat (2) @(negedge clk);
      chk("R10 busy during miss", int'(busy[1]), 1);
      req[1] = 1'b0;
      g = 0;
      while (!valid[1] && g < 200) begin
        @(negedge clk);
        g++;
      end
      rd = rdat[1];
      chk("R10 original read data", int'(rd), int'(shadow[1][8'h20]));
      chk("R10 one lookup", int'(ac1), 1);
    end
    expectRead(1, 8'h10, 1'b0, "R10 ignored write");
    chk("R10 no byte write", nByte[1], 0);

    // R6 R8 sweeps on write-through no-allocate build
    doReset();
    sweepWrite(1, 1'b0, "R8 sweep write");
    chk("R6 byte writes", nByte[1], 256);
    chk("R8 no fetch", nFetch[1], 0);
    sweepRead(1, "R6 sweep read");
    chk("R8 fetches", nFetch[1], 32);
    chk("R6 no writeback", nBlk[1], 0);
    chk("R11 accesses", int'(ac1), 512);
    chk("R11 hits", int'(hc1), 224);

    // R6 write hit forwarded as single byte
    expectRead(1, 8'h00, 1'b0, "R6 prep");
    writeExp(1, 8'h02, 8'h99, 1'b1, "R6 write hit");
    chk("R6 byte write count", nByte[1], 257);
    chk("R9 byte enable", int'(lastBe[1]), 8'h04);
    chk("R9 byte addr", int'(lastAddr[1]), 8'h02);
    peekChk(1, 8'h02, 8'h99, "R6 memory updated");
    expectRead(1, 8'h02, 1'b1, "R6 cache updated");

    // R8 write miss leaves cache unchanged
    f0 = nFetch[1];
    writeExp(1, 8'h48, 8'h11, 1'b0, "R8 write miss");
    chk("R8 no fetch on write", nFetch[1], f0);
    expectRead(1, 8'h48, 1'b0, "R8 not allocated");
    chk("R6 no writeback end", nBlk[1], 0);

    finishRun();
  end

endmodule